// File: doc/BRIEF.md
# Idle Mode Controller

This block sequences the clocks of a small processor core through its low-power states. When the core issues a sleep request, the controller samples an idle-enable bit, a two-bit clock-select field and four secondary-oscillator enable bits. From these it picks the next state: full sleep, primary-clock idle, secondary-clock idle or internal-RC idle. In every idle state the CPU clock enable is dropped and the peripheral clock enable stays high. In full sleep both enables are dropped.

The controller records which clock source feeds the system. It drives the primary-oscillator enable and keeps two status flags: one says the primary oscillator is stable, the other says the secondary oscillator is the running source. When the primary oscillator has to restart, it is declared stable only after a start-up count of ready cycles. A wake event starts a clock-switch delay, counted in cycles of the active source. The CPU clock enable returns on the cycle after that delay ends. The clock-select field is read only when a sleep request is accepted.

Top module: `pm_idle_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it rises: `pm_mode` is 0 (run), `cpu_clk_en` is 1, `per_clk_en` is 1, `pri_osc_en` is 1, `pri_stable` is 1 and `sec_running` is 0. The primary oscillator is the source.
- R2: A sleep request in run with `idle_en`=0 sets `pm_mode` to 4 and drops both clock enables on the sampling edge. The source and the flags are unchanged.
- R3: A sleep request with `idle_en`=1 and `clk_sel`=00 sets `pm_mode` to 1, drops `cpu_clk_en` and keeps `per_clk_en` at 1. If the primary oscillator was already the source, `pri_stable` stays 1 through entry, idle and wake.
- R4: A sleep request with `idle_en`=1, `clk_sel`=01 and at least one bit of `sec_en` set enters mode 2. On that same edge `pri_osc_en` and `pri_stable` go to 0 and `sec_running` goes to 1.
- R5: If `clk_sel`=01 and all four `sec_en` bits are 0, the source does not change. The idle mode matches the current source: 1 for primary, 2 for secondary, 3 for internal RC.
- R6: A sleep request with `idle_en`=1 and `clk_sel`=10 or 11 enters mode 3 with the internal RC as source. `pri_osc_en`, `pri_stable` and `sec_running` are then all 0.
- R7: Suppose a wake event is sampled in an idle or sleep state while the source is ready. `cpu_clk_en` and `per_clk_en` return to 1, and `pm_mode` returns to 0, on the edge CSD_CYCLES after the sampling edge. Before that edge `cpu_clk_en` stays 0 and the mode is held. The flags do not change.
- R8: Entering primary idle from another source raises `pri_osc_en`. With `pri_osc_rdy` held high, `pri_stable` rises on the OST_CYCLES-th edge, counting the entry edge. A wake accepted before that point starts its CSD_CYCLES count only once `pri_stable` is 1.
- R9: A wake event in run has no effect. So does a repeated wake during the delay. A sleep request outside run is ignored: the mode is held, and resume timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | One-cycle sleep request strobe from the core |
| idle_en | input | 1 | 1 selects an idle mode, 0 selects full sleep |
| clk_sel | input | 2 | Clock-source request: 00 primary, 01 secondary, 1x internal RC |
| sec_en | input | N_SEC_EN | Secondary-oscillator enable bits |
| wake_evt | input | 1 | Wake event |
| pri_osc_rdy | input | 1 | Primary oscillator reports it is oscillating |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pri_osc_en | output | 1 | Primary oscillator enable |
| pri_stable | output | 1 | Primary oscillator start-up count complete |
| sec_running | output | 1 | Secondary oscillator is the system source |
| pm_mode | output | 3 | 0 run, 1 primary idle, 2 secondary idle, 3 RC idle, 4 sleep |

## Verification
The bench sweeps every combination of `idle_en` and `clk_sel` with the secondary enables set to none, each single bit and all four. It repeats the sweep from each of the three starting sources. This separates a fallback idle from a real switch, and a restart of the primary oscillator from a primary idle that keeps it running. Each entry is followed by a wake, timed to the edge, which shows whether the delay depends on source readiness. Separate sequences send wakes in run, duplicate wakes, and sleep requests during idle and during the delay. In each case the bench checks that the mode and the resume edge do not move.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;

    typedef enum logic [2:0] {
        MODE_RUN      = 3'd0,
        MODE_PRI_IDLE = 3'd1,
        MODE_SEC_IDLE = 3'd2,
        MODE_RC_IDLE  = 3'd3,
        MODE_SLEEP    = 3'd4
    } pm_mode_e;

    typedef enum logic [1:0] {
        SRC_PRI = 2'd0,
        SRC_SEC = 2'd1,
        SRC_RC  = 2'd2
    } clk_src_e;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HALT = 2'd1,
        PH_WAKE = 2'd2
    } phase_e;

endpackage

// File: rtl/pm_idle_select.sv
module pm_idle_select
    import pwr_idle_pkg::*;
#(
    parameter int N_SEC_EN = 4
) (
    input  logic                idle_en,
    input  logic [1:0]          clk_sel,
    input  logic [N_SEC_EN-1:0] sec_en,
    input  clk_src_e            src_now,
    output pm_mode_e            mode_nx,
    output clk_src_e            src_nx
);

    clk_src_e want;

    always_comb begin
        case (clk_sel)
            2'b00:   want = SRC_PRI;
            2'b01:   want = (|sec_en) ? SRC_SEC : src_now;
            default: want = SRC_RC;
        endcase

        if (!idle_en) begin
            src_nx  = src_now;
            mode_nx = MODE_SLEEP;
        end else begin
            src_nx = want;
            case (want)
                SRC_PRI: mode_nx = MODE_PRI_IDLE;
                SRC_SEC: mode_nx = MODE_SEC_IDLE;
                default: mode_nx = MODE_RC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pm_osc_stable.sv
module pm_osc_stable #(
    parameter int OST_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pri_on,
    input  logic pri_rdy,
    output logic stable
);

    localparam int CW = $clog2(OST_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stable;
    } ost_t;

    ost_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!pri_on) begin
            r_d.cnt    = '0;
            r_d.stable = 1'b0;
        end else if (!r_q.stable) begin
            if (!pri_rdy) begin
                r_d.cnt = '0;
            end else if (r_q.cnt == CW'(OST_CYCLES - 1)) begin
                r_d.cnt    = '0;
                r_d.stable = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cnt    <= '0;
            r_q.stable <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign stable = r_q.stable;

    // R8: the flag only rises after a cycle with the oscillator on and ready
    a_r8_stable_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(pri_on && pri_rdy));

    // R4/R6: switching the oscillator off clears the flag on the next edge
    a_r4_off_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_on |=> !stable);

endmodule

// File: rtl/pm_idle_ctrl.sv
module pm_idle_ctrl
    import pwr_idle_pkg::*;
#(
    parameter int N_SEC_EN   = 4,
    parameter int OST_CYCLES = 1024,
    parameter int CSD_CYCLES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                idle_en,
    input  logic [1:0]          clk_sel,
    input  logic [N_SEC_EN-1:0] sec_en,
    input  logic                wake_evt,
    input  logic                pri_osc_rdy,
    output logic                cpu_clk_en,
    output logic                per_clk_en,
    output logic                pri_osc_en,
    output logic                pri_stable,
    output logic                sec_running,
    output logic [2:0]          pm_mode
);

    localparam int DW = $clog2(CSD_CYCLES + 1);

    typedef struct packed {
        phase_e   phase;
        pm_mode_e mode;
        clk_src_e src;
        logic [DW-1:0] dcnt;
        logic     cpu_en;
        logic     per_en;
    } ctl_t;

    ctl_t     r_d, r_q;
    pm_mode_e sel_mode;
    clk_src_e sel_src;
    logic     src_ready;

    pm_idle_select #(.N_SEC_EN(N_SEC_EN)) i_select (
        .idle_en (idle_en),
        .clk_sel (clk_sel),
        .sec_en  (sec_en),
        .src_now (r_q.src),
        .mode_nx (sel_mode),
        .src_nx  (sel_src)
    );

    pm_osc_stable #(.OST_CYCLES(OST_CYCLES)) i_ost (
        .clk     (clk),
        .rst_n   (rst_n),
        .pri_on  (r_d.src == SRC_PRI),
        .pri_rdy (pri_osc_rdy),
        .stable  (pri_stable)
    );

    assign src_ready = (r_q.src != SRC_PRI) || pri_stable;

    always_comb begin
        r_d = r_q;
        case (r_q.phase)
            PH_RUN: begin
                if (sleep_req) begin
                    r_d.phase  = PH_HALT;
                    r_d.mode   = sel_mode;
                    r_d.src    = sel_src;
                    r_d.cpu_en = 1'b0;
                    r_d.per_en = (sel_mode != MODE_SLEEP);
                end
            end
            PH_HALT: begin
                if (wake_evt) begin
                    r_d.phase = PH_WAKE;
                    r_d.dcnt  = '0;
                end
            end
            PH_WAKE: begin
                if (src_ready) begin
                    if (r_q.dcnt == DW'(CSD_CYCLES - 1)) begin
                        r_d.phase  = PH_RUN;
                        r_d.mode   = MODE_RUN;
                        r_d.cpu_en = 1'b1;
                        r_d.per_en = 1'b1;
                        r_d.dcnt   = '0;
                    end else begin
                        r_d.dcnt = r_q.dcnt + 1'b1;
                    end
                end
            end
            default: r_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase  <= PH_RUN;
            r_q.mode   <= MODE_RUN;
            r_q.src    <= SRC_PRI;
            r_q.dcnt   <= '0;
            r_q.cpu_en <= 1'b1;
            r_q.per_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_clk_en  = r_q.cpu_en;
    assign per_clk_en  = r_q.per_en;
    assign pri_osc_en  = (r_q.src == SRC_PRI);
    assign sec_running = (r_q.src == SRC_SEC);
    assign pm_mode     = r_q.mode;

    // R2: full sleep gates both clocks
    a_r2_sleep_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == MODE_SLEEP) |-> (!cpu_clk_en && !per_clk_en));

    // R4: secondary idle runs without the primary oscillator
    a_r4_sec_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == MODE_SEC_IDLE) |-> (sec_running && !pri_stable && !pri_osc_en));

    // R3: primary idle entered with a stable oscillator never loses the flag
    a_r3_pri_keeps_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.src == SRC_PRI && $past(pri_stable) && $past(r_q.src == SRC_PRI)) |-> pri_stable);

    // R7: the CPU clock only returns at the end of the delay, into run
    a_r7_resume_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (pm_mode == MODE_RUN && $past(r_q.phase == PH_WAKE)));

    // R9: while the CPU stays halted, the mode does not move
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && $past(!cpu_clk_en)) |-> $stable(pm_mode));

endmodule

// File: tb/test_pm_idle_ctrl.sv
module test_pm_idle_ctrl;

    localparam int OST = 16;
    localparam int CSD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       idle_en = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic [3:0] sec_en = 4'b0000;
    logic       wake_evt = 1'b0;
    logic       pri_osc_rdy = 1'b1;
    logic       cpu_clk_en, per_clk_en, pri_osc_en, pri_stable, sec_running;
    logic [2:0] pm_mode;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    int ex_src = 0;
    int ex_osts = 1;
    int cur_mode = 0;
    bit last_restart = 1'b0;

    always #2 clk = ~clk;

    pm_idle_ctrl #(.N_SEC_EN(4), .OST_CYCLES(OST), .CSD_CYCLES(CSD)) i_pm_idle_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
        .clk_sel(clk_sel), .sec_en(sec_en), .wake_evt(wake_evt),
        .pri_osc_rdy(pri_osc_rdy), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .pri_osc_en(pri_osc_en), .pri_stable(pri_stable), .sec_running(sec_running),
        .pm_mode(pm_mode)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic flags_chk(input string req);
        chk(req, "pri_osc_en", int'(pri_osc_en), (ex_src == 0) ? 1 : 0);
        chk(req, "sec_running", int'(sec_running), (ex_src == 1) ? 1 : 0);
        chk(req, "pri_stable", int'(pri_stable), ex_osts);
    endtask

    task automatic enter(input int ie, input int cs, input int en);
        int want, nsrc, nmode;
        string req;
        bit restart;
        want = (cs == 0) ? 0 : (cs == 1) ? ((en != 0) ? 1 : ex_src) : 2;
        if (ie == 0) begin
            nsrc = ex_src; nmode = 4; req = "R2";
        end else begin
            nsrc = want; nmode = want + 1;
            req = (cs == 0) ? "R3" : (cs == 1) ? ((en != 0) ? "R4" : "R5") : "R6";
        end
        restart = (nsrc == 0) && (ex_src != 0);
        idle_en = ie[0]; clk_sel = cs[1:0]; sec_en = en[3:0]; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        ex_src = nsrc;
        ex_osts = (nsrc == 0 && !restart) ? 1 : 0;
        chk(req, "pm_mode", int'(pm_mode), nmode);
        chk(req, "cpu_clk_en", int'(cpu_clk_en), 0);
        chk(req, "per_clk_en", int'(per_clk_en), (nmode != 4) ? 1 : 0);
        flags_chk(restart ? "R8" : req);
        cur_mode = nmode;
        last_restart = restart;
    endtask

    task automatic resume();
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        if (last_restart) begin
            // two edges since entry so far
            repeat (OST - 3) @(negedge clk);
            chk("R8", "pri_stable early", int'(pri_stable), 0);
            @(negedge clk);
            chk("R8", "pri_stable on time", int'(pri_stable), 1);
            ex_osts = 1;
            repeat (CSD - 1) @(negedge clk);
            chk("R8", "cpu_clk_en before delay end", int'(cpu_clk_en), 0);
            @(negedge clk);
            chk("R8", "cpu_clk_en after delay", int'(cpu_clk_en), 1);
            chk("R8", "pm_mode after resume", int'(pm_mode), 0);
        end else begin
            repeat (CSD - 1) @(negedge clk);
            chk("R7", "cpu_clk_en during delay", int'(cpu_clk_en), 0);
            chk("R7", "pm_mode during delay", int'(pm_mode), cur_mode);
            @(negedge clk);
            chk("R7", "cpu_clk_en resumed", int'(cpu_clk_en), 1);
            chk("R7", "per_clk_en resumed", int'(per_clk_en), 1);
            chk("R7", "pm_mode resumed", int'(pm_mode), 0);
            flags_chk("R7");
        end
        cur_mode = 0;
    endtask

    task automatic set_src(input int s);
        if (ex_src != s) begin
            enter(1, (s == 0) ? 0 : (s == 1) ? 1 : 2, 15);
            resume();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "pm_mode in reset", int'(pm_mode), 0);
        chk("R1", "cpu_clk_en in reset", int'(cpu_clk_en), 1);
        chk("R1", "per_clk_en in reset", int'(per_clk_en), 1);
        flags_chk("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pm_mode after reset", int'(pm_mode), 0);
        flags_chk("R1");

        for (int s = 0; s < 3; s++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int cs = 0; cs < 4; cs++) begin
                    for (int k = 0; k < 6; k++) begin
                        int en;
                        en = (k == 0) ? 0 : (k == 5) ? 15 : (1 << (k - 1));
                        set_src(s);
                        enter(ie, cs, en);
                        resume();
                    end
                end
            end
        end

        // R9: wake in run is ignored
        set_src(0);
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        @(negedge clk);
        chk("R9", "pm_mode after wake in run", int'(pm_mode), 0);
        chk("R9", "cpu_clk_en after wake in run", int'(cpu_clk_en), 1);

        // R9: sleep request while idle is ignored
        enter(1, 0, 0);
        idle_en = 1'b0; clk_sel = 2'b10; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R9", "pm_mode after sleep in idle", int'(pm_mode), 1);
        chk("R9", "per_clk_en after sleep in idle", int'(per_clk_en), 1);

        // R9: repeated wake and a sleep request during the delay
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        @(negedge clk);
        wake_evt = 1'b1; sleep_req = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0; sleep_req = 1'b0;
        chk("R9", "cpu_clk_en still held", int'(cpu_clk_en), 0);
        chk("R9", "pm_mode still idle", int'(pm_mode), 1);
        @(negedge clk);
        chk("R9", "cpu_clk_en on original edge", int'(cpu_clk_en), 1);
        chk("R9", "pm_mode back to run", int'(pm_mode), 0);
        @(negedge clk);
        chk("R9", "no late sleep entry", int'(pm_mode), 0);
        chk("R3", "pri_stable kept", int'(pri_stable), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1-chain actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule